// File: doc/BRIEF.md
# SPI Slave Hold-Pause Qualifier

This block lets an SPI slave pause a transfer without being deselected. It takes the raw active-low hold pin, the serial clock and the active-low chip select, brings them into the system clock domain through a chain of synchroniser flops, and produces a registered hold flag. The flag freezes the slave's shift engine and removes the serial-output enable. It also blocks the serial-clock edge strobes that the shift logic consumes.

Hold entry and hold exit always happen while the serial clock is low. If the hold pin changes while the serial clock is low, the flag follows it at once, after only the synchroniser delay. If the pin changes while the serial clock is high, the change waits until the serial clock next falls. Chip select has priority: while it is high the flag is clear and the transfer state is discarded.

A small bit-position counter sits behind the qualified rising-edge strobe. It shows that a paused transfer resumes at the same bit it stopped on. The shift engine can use the counter directly as its bit index.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, hold_o=0, so_oe_o=0, sck_rise_o=0, sck_fall_o=0 and bit_pos_o=0.
- R2: With chip select low and SCK low, a falling edge on hold_n_i sets hold_o. With default parameters the change is invisible after two clock rising edges and visible after the third, counting from the first edge after the input change.
- R3: With chip select low and SCK low, a rising edge on hold_n_i clears hold_o with the same three-edge latency.
- R4: If hold_n_i falls while SCK is high, hold_o stays 0 for as long as SCK stays high. It goes to 1 only after SCK falls.
- R5: If hold_n_i rises while SCK is high during hold, hold_o stays 1 for as long as SCK stays high. It clears only after SCK falls.
- R6: While hold_o=1, SCK rising and falling edges produce no sck_rise_o or sck_fall_o strobes, and bit_pos_o does not change.
- R7: While cs_n_i is high, hold_o=0, so_oe_o=0 and bit_pos_o=0 whatever hold_n_i does. When cs_n_i returns low with hold_n_i low and SCK low, hold_o sets again.
- R8: bit_pos_o increments by one on each qualified SCK rising edge, wrapping modulo 2^POS_W (8 by default). After a hold it continues from the value it had when frozen.
- R9: While the block is selected and not held, each SCK rising edge gives exactly one single-cycle sck_rise_o pulse and each falling edge gives exactly one sck_fall_o pulse. The two strobes are never high in the same cycle.
- R10: so_oe_o is 1 exactly when the block is selected and hold_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_n_i | input | 1 | Raw active-low hold pin |
| sck_i | input | 1 | Raw serial clock |
| cs_n_i | input | 1 | Raw active-low chip select |
| hold_o | output | 1 | Hold flag, registered |
| so_oe_o | output | 1 | Serial-output enable (selected and not held) |
| sck_rise_o | output | 1 | Qualified SCK rising-edge strobe |
| sck_fall_o | output | 1 | Qualified SCK falling-edge strobe |
| bit_pos_o | output | POS_W | Bit position within the current byte |

## Verification
The bench targets the two deferred cases: a hold request or a hold release that arrives while SCK is high. A design that acts on the pin level directly would change hold_o before SCK falls. The bench also clocks SCK during hold and checks that bit_pos_o and the strobe counts stay still. A design that leaks edges through would lose the bit position on resume. Deselecting during hold must clear both the flag and the position, and the three-edge latency and the eight-edge wrap are measured exactly.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
   typedef struct packed {
      logic cs_n;
      logic hold_n;
      logic sck;
   } pin_bus_t;

   localparam int PIN_W = $bits(pin_bus_t);
   localparam pin_bus_t PIN_IDLE = '{cs_n: 1'b1, hold_n: 1'b1, sck: 1'b0};
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
   parameter int               WIDTH  = 3,
   parameter int               STAGES = 2,
   parameter logic [WIDTH-1:0] IDLE   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_hold_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q [STAGES];

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chain_q[g] <= IDLE;
            else if (g == 0)
               chain_q[g] <= d_i;
            else
               chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
   import spi_hold_pkg::*;
#(
   parameter bit REG_STROBES = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  pin_bus_t pins_i,
   output logic     hold_o,
   output logic     so_oe_o,
   output logic     rise_o,
   output logic     fall_o
);
   logic hold_q;
   logic sck_d;
   logic rise_raw, fall_raw;

   // Hold only moves while SCK is low; chip select high wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           hold_q <= 1'b0;
      else if (pins_i.cs_n) hold_q <= 1'b0;
      else if (!pins_i.sck) hold_q <= !pins_i.hold_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= pins_i.sck;
   end

   assign rise_raw = pins_i.sck & ~sck_d & ~pins_i.cs_n & ~hold_q;
   assign fall_raw = ~pins_i.sck & sck_d & ~pins_i.cs_n & ~hold_q;

   generate
      if (REG_STROBES) begin : g_reg
         logic rise_q, fall_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rise_q <= 1'b0;
               fall_q <= 1'b0;
            end else begin
               rise_q <= rise_raw;
               fall_q <= fall_raw;
            end
         end
         assign rise_o = rise_q;
         assign fall_o = fall_q;
      end else begin : g_comb
         assign rise_o = rise_raw;
         assign fall_o = fall_raw;
      end
   endgenerate

   assign hold_o  = hold_q;
   assign so_oe_o = ~pins_i.cs_n & ~hold_q;

   // R4 R5: the flag changes only in a cycle that followed SCK low or deselect
   assert_hold_moves_on_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hold_q) |-> ($past(!pins_i.sck) || $past(pins_i.cs_n)));
   assert_deselect_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pins_i.cs_n |=> !hold_q);
   assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_o && fall_o));
endmodule

// File: rtl/spi_hold_pos.sv
module spi_hold_pos #(
   parameter int POS_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             step_i,
   output logic [POS_W-1:0] pos_o
);
   generate
      if (POS_W < 1) begin : g_bad_width
         $error("spi_hold_pos needs POS_W of at least one");
      end
   endgenerate

   logic [POS_W-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pos_q <= '0;
      else if (clear_i) pos_q <= '0;
      else if (step_i)  pos_q <= pos_q + 1'b1;
   end

   assign pos_o = pos_q;

   assert_pos_single_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> (pos_q == $past(pos_q)) || (pos_q == POS_W'($past(pos_q) + 1'b1)));
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
   import spi_hold_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int POS_W       = 3,
   parameter bit REG_STROBES = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_n_i,
   input  logic             sck_i,
   input  logic             cs_n_i,
   output logic             hold_o,
   output logic             so_oe_o,
   output logic             sck_rise_o,
   output logic             sck_fall_o,
   output logic [POS_W-1:0] bit_pos_o
);
   pin_bus_t raw_pins, sync_pins;

   assign raw_pins = '{cs_n: cs_n_i, hold_n: hold_n_i, sck: sck_i};

   spi_hold_sync #(
      .WIDTH  (PIN_W),
      .STAGES (SYNC_STAGES),
      .IDLE   (PIN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_pins),
      .q_o   (sync_pins)
   );

   spi_hold_gate #(
      .REG_STROBES (REG_STROBES)
   ) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins_i  (sync_pins),
      .hold_o  (hold_o),
      .so_oe_o (so_oe_o),
      .rise_o  (sck_rise_o),
      .fall_o  (sck_fall_o)
   );

   spi_hold_pos #(
      .POS_W (POS_W)
   ) u_pos (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (sync_pins.cs_n),
      .step_i  (sck_rise_o),
      .pos_o   (bit_pos_o)
   );

   // R6: a held, selected cycle leaves the bit position untouched
   assert_freeze_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_o && !sync_pins.cs_n) |=> $stable(bit_pos_o));
   // R10: output enable never coexists with hold
   assert_oe_off_in_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hold_o |-> !so_oe_o);
endmodule

// File: tb/spi_hold_ctrl_test.sv
module spi_hold_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int POS_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hold_n = 1'b1, sck = 1'b0, cs_n = 1'b1;
   logic hold_o, so_oe_o, rise_o, fall_o;
   logic [POS_W-1:0] pos;

   int total = 0, bad = 0;
   int n_rise = 0, n_fall = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_hold_ctrl #(.POS_W(POS_W)) uut (
      .clk(clk), .rst_n(rst_n), .hold_n_i(hold_n), .sck_i(sck), .cs_n_i(cs_n),
      .hold_o(hold_o), .so_oe_o(so_oe_o), .sck_rise_o(rise_o),
      .sck_fall_o(fall_o), .bit_pos_o(pos)
   );

   always @(posedge clk) begin
      if (rise_o) n_rise++;
      if (fall_o) n_fall++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_sck(input logic v);
      sck = v;
      idle(6);
   endtask

   task automatic t_reset;
      idle(1);
      chk(hold_o == 0, "R1 hold", hold_o, 0);
      chk(so_oe_o == 0, "R1 oe", so_oe_o, 0);
      chk(rise_o == 0 && fall_o == 0, "R1 strobes", rise_o | fall_o, 0);
      chk(pos == 0, "R1 pos", pos, 0);
   endtask

   task automatic t_enter_low;
      hold_n = 1'b0;
      idle(2);
      chk(hold_o == 0, "R2 latency early", hold_o, 0);
      idle(1);
      chk(hold_o == 1, "R2 latency on time", hold_o, 1);
      chk(so_oe_o == 0, "R10 oe in hold", so_oe_o, 0);
   endtask

   task automatic t_exit_low;
      hold_n = 1'b1;
      idle(2);
      chk(hold_o == 1, "R3 latency early", hold_o, 1);
      idle(1);
      chk(hold_o == 0, "R3 latency on time", hold_o, 0);
      chk(so_oe_o == 1, "R10 oe selected", so_oe_o, 1);
   endtask

   task automatic t_count;
      int r0 = n_rise, f0 = n_fall;
      logic [POS_W-1:0] p0 = pos;
      for (int i = 0; i < 3; i++) begin
         set_sck(1'b1);
         set_sck(1'b0);
      end
      chk(pos == POS_W'(p0 + 3), "R8 count", pos, POS_W'(p0 + 3));
      chk(n_rise - r0 == 3, "R9 rise strobes", n_rise - r0, 3);
      chk(n_fall - f0 == 3, "R9 fall strobes", n_fall - f0, 3);
      for (int i = 0; i < 8; i++) begin
         set_sck(1'b1);
         set_sck(1'b0);
      end
      chk(pos == POS_W'(p0 + 3), "R8 wrap", pos, POS_W'(p0 + 3));
   endtask

   task automatic t_freeze;
      int r0, f0;
      logic [POS_W-1:0] p0 = pos;
      hold_n = 1'b0;
      idle(6);
      r0 = n_rise; f0 = n_fall;
      for (int i = 0; i < 4; i++) begin
         set_sck(1'b1);
         set_sck(1'b0);
      end
      chk(pos == p0, "R6 pos frozen", pos, p0);
      chk(n_rise == r0 && n_fall == f0, "R6 no strobes", (n_rise - r0) + (n_fall - f0), 0);
      hold_n = 1'b1;
      idle(6);
      set_sck(1'b1);
      set_sck(1'b0);
      chk(pos == POS_W'(p0 + 1), "R8 resume", pos, POS_W'(p0 + 1));
   endtask

   task automatic t_enter_high;
      set_sck(1'b1);
      hold_n = 1'b0;
      idle(8);
      chk(hold_o == 0, "R4 wait while SCK high", hold_o, 0);
      set_sck(1'b0);
      chk(hold_o == 1, "R4 enter after fall", hold_o, 1);
   endtask

   task automatic t_exit_high;
      set_sck(1'b1);
      hold_n = 1'b1;
      idle(8);
      chk(hold_o == 1, "R5 stay while SCK high", hold_o, 1);
      set_sck(1'b0);
      chk(hold_o == 0, "R5 exit after fall", hold_o, 0);
   endtask

   task automatic t_deselect;
      set_sck(1'b1);
      set_sck(1'b0);
      hold_n = 1'b0;
      idle(6);
      cs_n = 1'b1;
      idle(6);
      chk(hold_o == 0, "R7 hold cleared", hold_o, 0);
      chk(so_oe_o == 0, "R7 oe off", so_oe_o, 0);
      chk(pos == 0, "R7 pos cleared", pos, 0);
      cs_n = 1'b0;
      idle(6);
      chk(hold_o == 1, "R7 hold again", hold_o, 1);
      hold_n = 1'b1;
      idle(6);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      t_reset();
      cs_n = 1'b0;
      idle(6);
      chk(so_oe_o == 1, "R10 oe selected", so_oe_o, 1);
      t_enter_low();
      t_exit_low();
      t_count();
      t_freeze();
      t_enter_high();
      t_exit_high();
      t_deselect();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            chk(1'b0, "watchdog", 0, 1);
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule